// File: doc/BRIEF.md
# Row-Hit-First DRAM Command Scheduler

This block decides the order in which a memory controller services its pending accesses. Requests arrive already split into bank, row and column, with a read/write flag and a tag. They wait in an eight-entry queue that keeps them in arrival order. The block records one open row for each of eight banks. On each cycle it may start at most one request. It prefers the oldest startable request that targets the row already open in its bank. If there is none, it takes the oldest startable request.

A started request is classified against its bank's open row, and the bank runs a fixed command sequence. A hit issues only a column command and keeps the bank busy for one step. An access to a bank with nothing open issues an activate and then, one step later, a column command, taking two steps. An access to a bank holding a different row issues a precharge, an activate and a column command one step apart, taking three steps. One step is `STEP` cycles (4 by default). After the column command the row stays open. When a bank's busy count expires, the request's tag is reported on the completion output.

Top module: `dram_sched`

## Requirements
- R1: While reset is asserted and after its release, the queue is empty: `req_ready` is 1 and neither `cmd_valid` nor `done_valid` is asserted.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 exactly when 8 requests are pending.
- R3: A request to a bank with no open row issues an activate (`cmd_kind`=1). It issues the column command 4 cycles later. Its completion appears 7 cycles after the activate, and the request issues 2 commands in total.
- R4: A request to the open row of its bank issues only the column command. Its completion appears 3 cycles after that command.
- R5: A request to a bank holding a different row issues a precharge (`cmd_kind`=0), an activate 4 cycles later and the column command 8 cycles after the precharge. Its completion appears 11 cycles after the precharge.
- R6: After a column command the row stays open in its bank (open-page policy), so a following request to the same row is a hit. Every command carries the bank's current target row.
- R7: Among requests whose bank is idle, a request to its bank's open row is started before any older request that is not a hit.
- R8: Among startable requests of equal class, the oldest in arrival order starts first. The column command carries that request's column.
- R9: A request whose bank is still busy is not started. The next request to that bank begins its command sequence two cycles after the previous completion.
- R10: At most one command is presented per cycle. A request is not started in a cycle where another bank will present a command in the following cycle.
- R11: `done_valid` pulses for one cycle per finished request, with `done_id` equal to that request's tag. At most one completion is reported per cycle.
- R12: Command codes are 0 for precharge, 1 for activate, 2 for a column read and 3 for a column write. A write request's column command uses code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | New request present |
| req_ready | output | 1 | Queue has a free entry |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_bank | input | 3 | Target bank |
| req_row | input | 8 | Target row |
| req_col | input | 6 | Target column |
| req_id | input | 4 | Request tag |
| cmd_valid | output | 1 | A command is presented this cycle |
| cmd_kind | output | 2 | 0 precharge, 1 activate, 2 read, 3 write |
| cmd_bank | output | 3 | Bank of the command |
| cmd_row | output | 8 | Row being opened or accessed |
| cmd_col | output | 6 | Column of the access |
| done_valid | output | 1 | A request finished this cycle |
| done_id | output | 4 | Tag of the finished request |

## Verification
Directed sequences on an idle controller separate the three access classes by their command count and spacing. Further sequences queue a conflicting request ahead of a hit to the same bank, which shows hit-first selection overriding age. Queueing several conflicts behind a busy bank shows that equal-class requests keep arrival order. Long random traffic over eight banks and only four rows mixes hits, conflicts, full-queue back-pressure and start deferrals between banks. A cycle-exact bench model compares every command and completion against the design.

// File: rtl/dram_sched.sv
module dram_sched #(
  parameter int NBANK  = 8,
  parameter int QDEPTH = 8,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int ID_W   = 4,
  parameter int STEP   = 4,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [ID_W-1:0]   req_id,
  output logic              cmd_valid,
  output logic [1:0]        cmd_kind,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id
);
  localparam int CNT_W  = $clog2(3*STEP+1);
  localparam int QIDX_W = $clog2(QDEPTH);
  localparam int QCNT_W = $clog2(QDEPTH+1);
  localparam logic [1:0] K_PRE = 2'd0, K_ACT = 2'd1, K_RD = 2'd2, K_WR = 2'd3;
  localparam logic [CNT_W-1:0] LAT_HIT   = CNT_W'(STEP);
  localparam logic [CNT_W-1:0] LAT_EMPTY = CNT_W'(2*STEP);
  localparam logic [CNT_W-1:0] LAT_CONF  = CNT_W'(3*STEP);
  localparam logic [CNT_W-1:0] GAP1      = CNT_W'(STEP+1);
  localparam logic [CNT_W-1:0] GAP2      = CNT_W'(2*STEP+1);
  localparam logic [CNT_W-1:0] LAST      = CNT_W'(1);

  typedef struct packed {
    logic              wr;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [ID_W-1:0]   id;
  } req_t;

  req_t              q [QDEPTH];
  logic [QCNT_W-1:0] q_cnt;

  logic [CNT_W-1:0]  b_cnt  [NBANK];
  logic              b_open [NBANK];
  logic [ROW_W-1:0]  b_row  [NBANK];
  logic [COL_W-1:0]  b_col  [NBANK];
  logic              b_wr   [NBANK];
  logic [ID_W-1:0]   b_id   [NBANK];

  logic              stall, sel_valid, hit_found;
  logic [QIDX_W-1:0] sel_idx, hit_idx, old_idx;
  logic [CNT_W-1:0]  sel_lat;
  logic [NBANK-1:0]  cmd_due, done_due;
  logic              push;
  req_t              in_req, sel_req;

  assign req_ready = q_cnt < QCNT_W'(QDEPTH);
  assign push      = req_valid && req_ready;
  assign in_req    = '{wr: req_write, bank: req_bank, row: req_row, col: req_col, id: req_id};

  always_comb begin
    stall = 1'b0;
    for (int b = 0; b < NBANK; b++)
      if (b_cnt[b] == GAP1 || b_cnt[b] == GAP2) stall = 1'b1;
  end

  always_comb begin
    sel_valid = 1'b0;
    hit_found = 1'b0;
    hit_idx   = '0;
    old_idx   = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (i < int'(q_cnt) && !stall && b_cnt[q[i].bank] == '0) begin
        if (!sel_valid) begin
          sel_valid = 1'b1;
          old_idx   = QIDX_W'(i);
        end
        if (!hit_found && b_open[q[i].bank] && b_row[q[i].bank] == q[i].row) begin
          hit_found = 1'b1;
          hit_idx   = QIDX_W'(i);
        end
      end
    end
  end

  assign sel_idx = hit_found ? hit_idx : old_idx;
  assign sel_req = q[sel_idx];
  assign sel_lat = hit_found ? LAT_HIT : (b_open[sel_req.bank] ? LAT_CONF : LAT_EMPTY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_cnt <= '0;
    end else begin
      for (int i = 0; i < QDEPTH-1; i++)
        if (sel_valid && i >= int'(sel_idx)) q[i] <= q[i+1];
      if (push) q[QIDX_W'(q_cnt - QCNT_W'(sel_valid))] <= in_req;
      q_cnt <= q_cnt + QCNT_W'(push) - QCNT_W'(sel_valid);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) begin
        b_cnt[b]  <= '0;
        b_open[b] <= 1'b0;
      end
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (sel_valid && sel_req.bank == BANK_W'(b)) begin
          b_cnt[b]  <= sel_lat;
          b_open[b] <= 1'b1;
          b_row[b]  <= sel_req.row;
          b_col[b]  <= sel_req.col;
          b_wr[b]   <= sel_req.wr;
          b_id[b]   <= sel_req.id;
        end else if (b_cnt[b] != '0) begin
          b_cnt[b] <= b_cnt[b] - LAST;
        end
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      cmd_due[b]  = b_cnt[b] == LAT_CONF || b_cnt[b] == LAT_EMPTY || b_cnt[b] == LAT_HIT;
      done_due[b] = b_cnt[b] == LAST;
    end
  end

  always_comb begin
    cmd_valid  = 1'b0;
    cmd_kind   = K_PRE;
    cmd_bank   = '0;
    cmd_row    = '0;
    cmd_col    = '0;
    done_valid = 1'b0;
    done_id    = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (cmd_due[b]) begin
        cmd_valid = 1'b1;
        cmd_bank  = BANK_W'(b);
        cmd_row   = b_row[b];
        cmd_col   = b_col[b];
        if (b_cnt[b] == LAT_CONF)       cmd_kind = K_PRE;
        else if (b_cnt[b] == LAT_EMPTY) cmd_kind = K_ACT;
        else                            cmd_kind = b_wr[b] ? K_WR : K_RD;
      end
      if (done_due[b]) begin
        done_valid = 1'b1;
        done_id    = b_id[b];
      end
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QCNT_W'(QDEPTH));

  assert_one_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_due));

  assert_start_emits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |=> cmd_valid);

  assert_one_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_due));

  assert_col_row_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind[1]) |-> b_open[cmd_bank]);
endmodule

// File: tb/test_dram_sched.sv
module test_dram_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8, QD = 8, STEP = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_bank = '0;
  logic [7:0] req_row = '0;
  logic [5:0] req_col = '0;
  logic [3:0] req_id = '0;
  logic       req_ready, cmd_valid, done_valid;
  logic [1:0] cmd_kind;
  logic [2:0] cmd_bank;
  logic [7:0] cmd_row;
  logic [5:0] cmd_col;
  logic [3:0] done_id;

  dram_sched i_dram_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_id(req_id), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .done_valid(done_valid), .done_id(done_id)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit chk_on = 0, finished = 0;
  int mq_bank[QD], mq_row[QD], mq_col[QD], mq_wr[QD], mq_id[QD];
  int mq_n;
  int mb_cnt[NB], mb_open[NB], mb_row[NB], mb_col[NB], mb_wr[NB], mb_id[NB];
  int done_at[16], last_pre[NB], last_act[NB], last_col[NB], last_ck[NB], ncmd[NB];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lat_of(input int b, input int row);
    if (mb_open[b] != 0 && mb_row[b] == row) return STEP;
    if (mb_open[b] != 0) return 3*STEP;
    return 2*STEP;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mq_n = 0;
      for (int b = 0; b < NB; b++) begin mb_cnt[b] = 0; mb_open[b] = 0; end
    end else begin
      int sel, hsel, lat, b;
      bit stall, push;
      push = req_valid && mq_n < QD;
      stall = 0;
      for (int k = 0; k < NB; k++) if (mb_cnt[k] == STEP+1 || mb_cnt[k] == 2*STEP+1) stall = 1;
      sel = -1; hsel = -1;
      for (int i = 0; i < mq_n; i++)
        if (!stall && mb_cnt[mq_bank[i]] == 0) begin
          if (sel < 0) sel = i;
          if (hsel < 0 && mb_open[mq_bank[i]] != 0 && mb_row[mq_bank[i]] == mq_row[i]) hsel = i;
        end
      if (hsel >= 0) sel = hsel;
      for (int k = 0; k < NB; k++) if (mb_cnt[k] > 0) mb_cnt[k]--;
      if (sel >= 0) begin
        b = mq_bank[sel];
        lat = lat_of(b, mq_row[sel]);
        mb_cnt[b] = lat; mb_open[b] = 1; mb_row[b] = mq_row[sel];
        mb_col[b] = mq_col[sel]; mb_wr[b] = mq_wr[sel]; mb_id[b] = mq_id[sel];
        for (int i = sel; i < mq_n - 1; i++) begin
          mq_bank[i] = mq_bank[i+1]; mq_row[i] = mq_row[i+1]; mq_col[i] = mq_col[i+1];
          mq_wr[i] = mq_wr[i+1]; mq_id[i] = mq_id[i+1];
        end
        mq_n--;
      end
      if (push) begin
        mq_bank[mq_n] = req_bank; mq_row[mq_n] = req_row; mq_col[mq_n] = req_col;
        mq_wr[mq_n] = req_write; mq_id[mq_n] = req_id;
        mq_n++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      int ev, ek, eb, er, ec, dv, di;
      ev = 0; ek = 0; eb = 0; er = 0; ec = 0; dv = 0; di = 0;
      for (int b = 0; b < NB; b++) begin
        if (mb_cnt[b] == 3*STEP || mb_cnt[b] == 2*STEP || mb_cnt[b] == STEP) begin
          ev = 1; eb = b; er = mb_row[b]; ec = mb_col[b];
          ek = (mb_cnt[b] == 3*STEP) ? 0 : (mb_cnt[b] == 2*STEP) ? 1 : (mb_wr[b] != 0 ? 3 : 2);
        end
        if (mb_cnt[b] == 1) begin dv = 1; di = mb_id[b]; end
      end
      chk("R2 req_ready", req_ready, mq_n < QD);
      chk("R10 cmd_valid", cmd_valid, ev);
      if (ev != 0) begin
        chk("R12 cmd_kind", cmd_kind, ek);
        chk("R7 cmd_bank", cmd_bank, eb);
        chk("R6 cmd_row", cmd_row, er);
        chk("R8 cmd_col", cmd_col, ec);
      end
      chk("R3 done_valid", done_valid, dv);
      if (dv != 0) chk("R11 done_id", done_id, di);
    end
    if (rst_n) begin
      if (cmd_valid) begin
        ncmd[cmd_bank]++;
        case (cmd_kind)
          2'd0: last_pre[cmd_bank] = cyc;
          2'd1: last_act[cmd_bank] = cyc;
          default: begin last_col[cmd_bank] = cyc; last_ck[cmd_bank] = cmd_kind; end
        endcase
      end
      if (done_valid) done_at[done_id] = cyc;
    end
  end

  task automatic send(input int b, input int row, input int col, input int wr, input int id);
    @(negedge clk);
    req_valid = 1'b1; req_bank = 3'(b); req_row = 8'(row); req_col = 6'(col);
    req_write = wr[0]; req_id = 4'(id);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int id);
    for (int k = 0; k < 400 && done_at[id] < 0; k++) @(negedge clk);
    chk("R11 completion seen", done_at[id] >= 0, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R1..run did not end actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) done_at[i] = -1;
    for (int b = 0; b < NB; b++) begin ncmd[b] = 0; last_pre[b] = -1; last_act[b] = -1; last_col[b] = -1; end
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", req_ready, 1);
    chk("R1 no cmd in reset", cmd_valid, 0);
    chk("R1 no done in reset", done_valid, 0);
    rst_n = 1'b1;
    chk_on = 1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 no cmd after reset", cmd_valid, 0);

    send(0, 5, 1, 0, 1); wait_done(1);
    chk("R3 col after act", last_col[0], last_act[0] + 4);
    chk("R3 done after act", done_at[1], last_act[0] + 7);
    chk("R3 command count", ncmd[0], 2);
    chk("R12 read code", last_ck[0], 2);

    ncmd[0] = 0;
    send(0, 5, 2, 0, 2); wait_done(2);
    chk("R4 hit single command", ncmd[0], 1);
    chk("R4 done after col", done_at[2], last_col[0] + 3);

    ncmd[0] = 0;
    send(0, 9, 3, 1, 3); wait_done(3);
    chk("R5 command count", ncmd[0], 3);
    chk("R5 act after pre", last_act[0], last_pre[0] + 4);
    chk("R5 col after pre", last_col[0], last_pre[0] + 8);
    chk("R5 done after pre", done_at[3], last_pre[0] + 11);
    chk("R12 write code", last_ck[0], 3);

    ncmd[0] = 0;
    send(0, 9, 4, 0, 12); wait_done(12);
    chk("R6 row kept open", ncmd[0], 1);

    send(2, 3, 0, 0, 4); send(2, 7, 0, 0, 5); send(2, 3, 0, 0, 6);
    wait_done(5);
    chk("R7 hit before older conflict", done_at[6] < done_at[5], 1);
    chk("R9 waits for busy bank", done_at[6], done_at[4] + 5);

    send(2, 8, 0, 0, 7); send(2, 9, 0, 0, 8); send(2, 10, 0, 0, 9);
    wait_done(9);
    chk("R8 oldest of equals first", done_at[8] < done_at[9], 1);
    chk("R8 start after previous", done_at[8], done_at[7] + 13);

    send(4, 1, 0, 0, 10); @(negedge clk); send(5, 1, 0, 0, 11);
    wait_done(11);
    chk("R10 distinct cycles act", last_act[5] != last_col[4] && last_act[5] != last_act[4], 1);
    chk("R10 distinct cycles col", last_col[5] != last_col[4] && last_col[5] != last_act[4], 1);

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      req_valid = ($urandom % 100) < 45;
      req_bank = 3'($urandom % NB);
      req_row = 8'($urandom % 4);
      req_col = 6'($urandom);
      req_write = 1'($urandom);
      req_id = 4'($urandom);
    end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (200) @(negedge clk);
    chk("R2 queue drained", req_ready, 1);
    finished = 1;
    summary();
    $finish;
  end
endmodule